// File: doc/BRIEF.md
# Wait-State Acknowledge Generator

This block produces the active-low data transfer acknowledge for an asynchronous 68000-style processor bus. A short delay line made of registered stages is held empty while both data strobes are inactive. Once either strobe goes low, a 1 advances one stage per rising bus clock edge. Each class of device takes its acknowledge from a different stage, so each class gets a fixed latency.

With the default parameters, RAM acknowledges with no wait states, I/O with one and ROM with three. A fourth select, for a mid-speed class, uses the spare two-wait stage. While a memory refresh is active the line keeps its contents, which stretches the cycle. The first stage also gates the peripheral read and write strobes, according to the buffered read/write level. Address decoding and the bus-error timeout are left to the surrounding logic.

Top module: `wait_dtack_gen`

## Requirements
- R1: While both `uds_ni` and `lds_ni` are high, `dtack_no`, `rd_no` and `wr_no` are high and the delay line is empty. All three return high in the same cycle in which the strobes are released.
- R2: While at least one strobe is low (either strobe alone is enough), one more stage of the delay line fills on each rising clock edge, starting at the first edge after the strobe fell. Stages fill in order, first stage first.
- R3: On an edge where `refresh_i` is high, the delay line keeps its contents. Each such edge adds one cycle to the acknowledge latency.
- R4: With `ram_sel_i` high and `berr_ni` high, `dtack_no` goes low once the first stage is set (0 wait states).
- R5: With `berr_ni` low, a RAM selection never drives `dtack_no` low.
- R6: With `io_sel_i` high, `dtack_no` goes low once the second stage is set (1 wait state).
- R7: With `rom_sel_i` high, `dtack_no` goes low once the fourth stage is set (3 wait states). With `mid_sel_i` high, it goes low once the third stage is set (2 wait states).
- R8: While the first stage is set, `rd_no` is low if `rw_i` is 1 (read) and `wr_no` is low if `rw_i` is 0 (write). The two are never low together.
- R9: With no select high, `dtack_no` stays high for the whole strobe period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| uds_ni | input | 1 | Upper data strobe, active low |
| lds_ni | input | 1 | Lower data strobe, active low |
| rw_i | input | 1 | Buffered read/write level, 1 = read |
| refresh_i | input | 1 | Refresh in progress, stalls the delay line |
| berr_ni | input | 1 | Bus error, active low, blocks RAM acknowledge |
| ram_sel_i | input | 1 | RAM selected |
| io_sel_i | input | 1 | I/O device selected |
| mid_sel_i | input | 1 | Two-wait-state device selected |
| rom_sel_i | input | 1 | ROM selected |
| dtack_no | output | 1 | Data transfer acknowledge, active low |
| rd_no | output | 1 | Peripheral read strobe, active low |
| wr_no | output | 1 | Peripheral write strobe, active low |

## Verification
In a zero-wait RAM cycle, the peripheral read or write strobe and the acknowledge fall on the same clock edge, because both come from the first stage. The bench runs RAM reads and writes. At the sample where the acknowledge first appears, it checks both the latency and the strobe levels together.

Refresh is the second event that can overlap a bus cycle. The bench raises refresh in the same cycle as the strobe and holds it for several edges. It then expects the measured latency to grow by exactly that number of edges.

// File: rtl/wait_pkg.sv
package wait_pkg;
  localparam int unsigned DEF_DEPTH     = 4;
  localparam int unsigned DEF_RAM_WAITS = 0;
  localparam int unsigned DEF_IO_WAITS  = 1;
  localparam int unsigned DEF_MID_WAITS = 2;
  localparam int unsigned DEF_ROM_WAITS = 3;
endpackage

// File: rtl/wait_delay_line.sv
module wait_delay_line #(
  parameter int unsigned DEPTH = wait_pkg::DEF_DEPTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             hold_i,
  output logic [DEPTH-1:0] taps_o
);
  logic [DEPTH-1:0] line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     line_q <= '0;
    else if (clr_i)  line_q <= '0;
    else if (!hold_i) line_q <= {line_q[DEPTH-2:0], 1'b1};
  end

  // clear acts at once on the outputs, like an async clear
  assign taps_o = clr_i ? '0 : line_q;
endmodule

// File: rtl/wait_ack_mux.sv
module wait_ack_mux #(
  parameter int unsigned DEPTH     = wait_pkg::DEF_DEPTH,
  parameter int unsigned RAM_WAITS = wait_pkg::DEF_RAM_WAITS,
  parameter int unsigned IO_WAITS  = wait_pkg::DEF_IO_WAITS,
  parameter int unsigned MID_WAITS = wait_pkg::DEF_MID_WAITS,
  parameter int unsigned ROM_WAITS = wait_pkg::DEF_ROM_WAITS
) (
  input  logic [DEPTH-1:0] taps_i,
  input  logic             ram_sel_i,
  input  logic             io_sel_i,
  input  logic             mid_sel_i,
  input  logic             rom_sel_i,
  input  logic             berr_ni,
  output logic             dtack_no
);
  logic ram_ack, io_ack, mid_ack, rom_ack;

  assign ram_ack  = ram_sel_i & berr_ni & taps_i[RAM_WAITS];
  assign io_ack   = io_sel_i  & taps_i[IO_WAITS];
  assign mid_ack  = mid_sel_i & taps_i[MID_WAITS];
  assign rom_ack  = rom_sel_i & taps_i[ROM_WAITS];
  assign dtack_no = ~(ram_ack | io_ack | mid_ack | rom_ack);
endmodule

// File: rtl/wait_rw_strobe.sv
module wait_rw_strobe (
  input  logic first_tap_i,
  input  logic rw_i,
  output logic rd_no,
  output logic wr_no
);
  assign rd_no = ~(first_tap_i & rw_i);
  assign wr_no = ~(first_tap_i & ~rw_i);
endmodule

// File: rtl/wait_dtack_gen.sv
module wait_dtack_gen #(
  parameter int unsigned DEPTH     = wait_pkg::DEF_DEPTH,
  parameter int unsigned RAM_WAITS = wait_pkg::DEF_RAM_WAITS,
  parameter int unsigned IO_WAITS  = wait_pkg::DEF_IO_WAITS,
  parameter int unsigned MID_WAITS = wait_pkg::DEF_MID_WAITS,
  parameter int unsigned ROM_WAITS = wait_pkg::DEF_ROM_WAITS
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic uds_ni,
  input  logic lds_ni,
  input  logic rw_i,
  input  logic refresh_i,
  input  logic berr_ni,
  input  logic ram_sel_i,
  input  logic io_sel_i,
  input  logic mid_sel_i,
  input  logic rom_sel_i,
  output logic dtack_no,
  output logic rd_no,
  output logic wr_no
);
  logic             strobe_act;
  logic [DEPTH-1:0] tap_w;

  assign strobe_act = ~(uds_ni & lds_ni);

  wait_delay_line #(.DEPTH(DEPTH)) u_line (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (~strobe_act),
    .hold_i(refresh_i),
    .taps_o(tap_w)
  );

  wait_ack_mux #(
    .DEPTH(DEPTH), .RAM_WAITS(RAM_WAITS), .IO_WAITS(IO_WAITS),
    .MID_WAITS(MID_WAITS), .ROM_WAITS(ROM_WAITS)
  ) u_mux (
    .taps_i   (tap_w),
    .ram_sel_i(ram_sel_i),
    .io_sel_i (io_sel_i),
    .mid_sel_i(mid_sel_i),
    .rom_sel_i(rom_sel_i),
    .berr_ni  (berr_ni),
    .dtack_no (dtack_no)
  );

  wait_rw_strobe u_rw (
    .first_tap_i(tap_w[0]),
    .rw_i       (rw_i),
    .rd_no      (rd_no),
    .wr_no      (wr_no)
  );
endmodule

// File: rtl/wait_dtack_gen_chk.sv
module wait_dtack_gen_chk #(
  parameter int unsigned DEPTH = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             uds_ni,
  input logic             lds_ni,
  input logic             refresh_i,
  input logic             berr_ni,
  input logic             ram_sel_i,
  input logic             io_sel_i,
  input logic             mid_sel_i,
  input logic             rom_sel_i,
  input logic             dtack_no,
  input logic             rd_no,
  input logic             wr_no,
  input logic [DEPTH-1:0] tap_w
);
  logic act;
  assign act = ~(uds_ni & lds_ni);

  p_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act |-> (dtack_no && rd_no && wr_no && tap_w == '0));

  p_fill_order_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tap_w == DEPTH'((1 << $countones(tap_w)) - 1));

  p_refresh_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act && refresh_i |=> (!act || $stable(tap_w)));

  p_ram_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(act) && ram_sel_i && berr_ni && !refresh_i
      |=> (!act || !ram_sel_i || !berr_ni || !dtack_no));

  p_berr_block_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !berr_ni && !io_sel_i && !mid_sel_i && !rom_sel_i |-> dtack_no);

  p_rw_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_no && !wr_no));

  p_no_sel_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ram_sel_i && !io_sel_i && !mid_sel_i && !rom_sel_i |-> dtack_no);
endmodule

bind wait_dtack_gen wait_dtack_gen_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .uds_ni(uds_ni), .lds_ni(lds_ni),
  .refresh_i(refresh_i), .berr_ni(berr_ni), .ram_sel_i(ram_sel_i),
  .io_sel_i(io_sel_i), .mid_sel_i(mid_sel_i), .rom_sel_i(rom_sel_i),
  .dtack_no(dtack_no), .rd_no(rd_no), .wr_no(wr_no), .tap_w(tap_w)
);

// File: tb/wait_dtack_gen_tb.sv
module wait_dtack_gen_tb;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic uds_ni = 1'b1, lds_ni = 1'b1, rw_i = 1'b1, refresh_i = 1'b0, berr_ni = 1'b1;
  logic ram_sel_i = 1'b0, io_sel_i = 1'b0, mid_sel_i = 1'b0, rom_sel_i = 1'b0;
  logic dtack_no, rd_no, wr_no;

  always #2 clk = ~clk;

  wait_dtack_gen u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .uds_ni(uds_ni), .lds_ni(lds_ni),
    .rw_i(rw_i), .refresh_i(refresh_i), .berr_ni(berr_ni),
    .ram_sel_i(ram_sel_i), .io_sel_i(io_sel_i), .mid_sel_i(mid_sel_i),
    .rom_sel_i(rom_sel_i), .dtack_no(dtack_no), .rd_no(rd_no), .wr_no(wr_no)
  );

  typedef struct {
    int    lat;
    logic  rw;
    string req;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_err = 0;
  bit   finished = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: latency counted in falling-edge samples since strobe assertion
  int mon_lat = 0;
  bit mon_done = 1'b0;
  always @(negedge clk) begin
    if (!(uds_ni && lds_ni)) begin
      if (!mon_done) begin
        mon_lat++;
        if (!dtack_no) begin
          mon_done = 1'b1;
          if (exp_q.size() == 0) begin
            check(1'b0, "R9 unexpected acknowledge", 0, 1);
          end else begin
            exp_t e;
            e = exp_q.pop_front();
            check(mon_lat == e.lat, e.req, mon_lat, e.lat);
            check(rd_no == !e.rw, {e.req, "/R8 rd"}, int'(rd_no), int'(!e.rw));
            check(wr_no == e.rw,  {e.req, "/R8 wr"}, int'(wr_no), int'(e.rw));
          end
        end
      end
    end else begin
      mon_lat  = 0;
      mon_done = 1'b0;
    end
  end

  // sel: {ram, io, mid, rom}; exp_lat 0 means no acknowledge expected
  task automatic run_cycle(input logic [3:0] sel, input logic rw, input logic u_on,
                           input logic l_on, input logic berr_n, input int refr,
                           input int exp_lat, input string req);
    @(posedge clk); #1;
    if (exp_lat > 0) begin
      exp_t e;
      e.lat = exp_lat; e.rw = rw; e.req = req;
      exp_q.push_back(e);
    end
    {ram_sel_i, io_sel_i, mid_sel_i, rom_sel_i} = sel;
    rw_i = rw; berr_ni = berr_n;
    uds_ni = !u_on; lds_ni = !l_on;
    refresh_i = (refr > 0);
    for (int k = 0; k < refr; k++) @(posedge clk);
    if (refr > 0) begin #1; refresh_i = 1'b0; end
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (exp_lat == 0) check(dtack_no == 1'b1, req, int'(dtack_no), 1);
    end
    @(posedge clk); #1;
    uds_ni = 1'b1; lds_ni = 1'b1;
    @(negedge clk);
    check(dtack_no && rd_no && wr_no, "R1 release", int'({dtack_no, rd_no, wr_no}), 7);
    {ram_sel_i, io_sel_i, mid_sel_i, rom_sel_i} = '0;
    berr_ni = 1'b1;
    if (exp_q.size() != 0) begin
      check(1'b0, {req, " missing acknowledge"}, 0, exp_lat);
      exp_q.delete();
    end
  endtask

  initial begin
    #(4 * 20000);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(dtack_no && rd_no && wr_no, "R1 reset", int'({dtack_no, rd_no, wr_no}), 7);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    check(dtack_no && rd_no && wr_no, "R1 idle", int'({dtack_no, rd_no, wr_no}), 7);

    // expected latency = waits + 2 + refresh edges
    run_cycle(4'b1000, 1'b1, 1, 1, 1'b1, 0, 2, "R4 ram read");
    run_cycle(4'b1000, 1'b0, 1, 0, 1'b1, 0, 2, "R4 ram write uds");
    run_cycle(4'b0100, 1'b1, 0, 1, 1'b1, 0, 3, "R6 io lds");
    run_cycle(4'b0010, 1'b0, 1, 1, 1'b1, 0, 4, "R7 mid");
    run_cycle(4'b0001, 1'b1, 1, 1, 1'b1, 0, 5, "R7 rom");
    run_cycle(4'b0001, 1'b1, 1, 0, 1'b1, 3, 8, "R3 rom refresh");
    run_cycle(4'b1000, 1'b1, 0, 1, 1'b1, 2, 4, "R3 ram refresh");
    run_cycle(4'b0100, 1'b0, 1, 1, 1'b1, 1, 4, "R2 io refresh");
    run_cycle(4'b1000, 1'b1, 1, 1, 1'b0, 0, 0, "R5 berr blocks ram");
    run_cycle(4'b0000, 1'b1, 1, 1, 1'b1, 0, 0, "R9 no select");
    run_cycle(4'b0000, 1'b0, 0, 1, 1'b1, 2, 0, "R9 no select refresh");
    // back-to-back cycles: line must restart empty (R2)
    run_cycle(4'b0001, 1'b0, 0, 1, 1'b1, 0, 5, "R2 rom restart");
    run_cycle(4'b1000, 1'b0, 1, 1, 1'b1, 0, 2, "R8 ram write");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule